// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. The host writes one character at a time into a one-entry holding register. The character moves into a shift engine as soon as the engine is free and transmission is permitted. Each frame has a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and a high stop interval. Bit timing comes from an external tick enable (`clk_en`) divided by a programmable multiplier.

Sending is allowed only while the transmit enable is set, clear-to-send is low (active), and no break is requested. A ready output tells the host that the holding register can take a character. An empty output shows that the engine is idle with nothing waiting. A break command forces the line low. When break is released, the line is held high for a full bit time before any new frame starts.

Top module: `serial_tx_buffered`

## Requirements
- R1: A character moves from the holding register into the engine only in a cycle where `tx_enable`=1, `cts_n`=0 and `send_break`=0. Otherwise it waits and the idle line stays high.
- R2: `tx_ready` is 1 while the holding register is empty. It goes to 0 the cycle after an accepted write, and back to 1 the cycle after the character moves into the engine. A write while the holding register is full is ignored. This includes a write in the same cycle as the transfer.
- R3: A frame is a low start bit, then N = 5 + `cfg_len` data bits with the least significant bit first (`cfg_len` 00→5 … 11→8). One bit lasts 1, 16 or 64 `clk_en` pulses for `cfg_mult` 01, 10, 11. Code 00 is treated as 01. The line goes low the cycle after the transfer.
- R4: With `cfg_par_en`=1, one parity bit follows the data bits. `cfg_par_odd`=0 makes the count of ones over the data and parity bits even. `cfg_par_odd`=1 makes it odd. With `cfg_par_en`=0 there is no parity bit.
- R5: The stop interval is high. `cfg_stop` 01 gives 1 bit, 10 gives 1.5 bits and 11 gives 2 bits; 00 is treated as 1 bit. At `cfg_mult` 01 (or 00), the 1.5 setting gives 1 bit.
- R6: If a character is waiting and sending is permitted when the stop interval ends, its start bit follows with no idle gap.
- R7: `tx_empty` is 1 exactly when the engine is idle and the holding register is empty. The line is high whenever `tx_empty` is 1.
- R8: While `send_break`=1 the line is forced low. From idle this happens the next cycle. During a frame it happens at the next bit boundary, and the rest of that character is dropped.
- R9: After `send_break` returns to 0, the line is high for one full bit time (the live `cfg_mult`) before any start bit.
- R10: Length, parity and stop settings and the multiplier are captured when a character enters the engine. Changes during a frame do not alter that frame.
- R11: After reset, `txd`=1, `tx_ready`=1 and `tx_empty`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Tick enable that paces bit timing |
| wr_stb | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Character written by the host |
| cfg_mult | input | 2 | Ticks per bit: 01=1, 10=16, 11=64 (00 as 01) |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Add a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop | input | 2 | Stop length: 01=1, 10=1.5, 11=2 bits |
| tx_enable | input | 1 | Transmit enable command |
| send_break | input | 1 | Force the line low |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial line, high when idle |
| tx_ready | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | Engine idle and no character waiting |

## Verification
Two functions can fall in the same cycle. The end of a stop interval, where the engine takes the next character, can coincide with a host write or a break request. The bench provokes the write case by holding a character back while disabled, then re-enabling and writing in the same cycle. It also drives a random stream that keeps the holding register busy against frame ends. A behavioural segment-queue model judges every cycle. It decides from its own pre-edge state whether a write is dropped, whether a back-to-back start occurs, and whether break wins over the next load at a bit boundary.

// File: rtl/stx_pkg.sv
// Shared encodings for the buffered serial transmitter.
// Assumes: the two-bit multiplier and stop codes are decoded only here and in the timing helper.
package stx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK,
        ST_MARK
    } stx_state_e;

    localparam logic [1:0] MUL_X16  = 2'b10;
    localparam logic [1:0] MUL_X64  = 2'b11;
    localparam logic [1:0] STP_HALF = 2'b10;
    localparam logic [1:0] STP_TWO  = 2'b11;
endpackage

// File: rtl/stx_timing.sv
// Turns the multiplier and stop codes into tick counts for one bit and for the stop interval.
// Assumes: the doubled slowest/medium/fast tick counts fit in CNT_W bits.
module stx_timing
    import stx_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int SLOW_TICKS = 1,
    parameter int MID_TICKS  = 16,
    parameter int FAST_TICKS = 64
) (
    input  logic [1:0]       mult,
    input  logic [1:0]       stop,
    output logic [CNT_W-1:0] bit_ticks,
    output logic [CNT_W-1:0] stop_ticks
);
    logic can_halve;

    // Decode ticks per bit and the stop length; the half bit exists only above the slowest rate.
    always_comb begin
        case (mult)
            MUL_X16: bit_ticks = CNT_W'(MID_TICKS);
            MUL_X64: bit_ticks = CNT_W'(FAST_TICKS);
            default: bit_ticks = CNT_W'(SLOW_TICKS);
        endcase
        can_halve = (mult == MUL_X16) || (mult == MUL_X64);
        case (stop)
            STP_HALF: stop_ticks = can_halve ? bit_ticks + (bit_ticks >> 1) : bit_ticks;
            STP_TWO:  stop_ticks = bit_ticks << 1;
            default:  stop_ticks = bit_ticks;
        endcase
    end
endmodule

// File: rtl/stx_hold.sv
// One-entry holding register between the host and the shift engine.
// Assumes: 'take' is raised only while the register is full.
module stx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    // Accept a write only when empty; release the entry when the engine takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_stb && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

    // R2: a full entry is never overwritten by a later write
    assert_no_overwrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_stb) |=> $stable(data));
endmodule

// File: rtl/stx_engine.sv
// Shift engine: frames one character with start, data, parity and stop, and handles break and recovery mark.
// Assumes: 'tick' paces bit timing; settings are captured on 'load' and kept until the next load.
module stx_engine
    import stx_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              can_load,
    input  logic              brk,
    input  logic [DATA_W-1:0] load_data,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [CNT_W-1:0]  bit_ticks,
    input  logic [CNT_W-1:0]  stop_ticks,
    output logic              load,
    output logic              txd,
    output logic              idle
);
    localparam int IDX_W = $clog2(DATA_W);

    stx_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  l_len_m1;
    logic              l_par_en;
    logic              l_par_bit;
    logic [CNT_W-1:0]  l_bit;
    logic [CNT_W-1:0]  l_stop;

    logic [IDX_W-1:0]  len_m1;
    logic [DATA_W-1:0] len_mask;
    logic              par_bit;
    logic [CNT_W-1:0]  cur_ticks;
    logic              seg_last;

    // Derive the live data length, its mask and the parity of the waiting character.
    always_comb begin
        len_m1 = IDX_W'(DATA_W - 4) + IDX_W'(cfg_len);
        for (int i = 0; i < DATA_W; i++) begin
            len_mask[i] = (i <= int'(len_m1));
        end
        par_bit = (^(load_data & len_mask)) ^ cfg_par_odd;
    end

    // Pick the length of the current segment and detect its final tick.
    always_comb begin
        case (st)
            ST_STOP: cur_ticks = l_stop;
            ST_MARK: cur_ticks = bit_ticks;
            default: cur_ticks = l_bit;
        endcase
        seg_last = (cnt == cur_ticks - 1'b1);
    end

    // Take a character from idle, or straight after the last stop tick.
    assign load = can_load && !brk &&
                  ((st == ST_IDLE) || (st == ST_STOP && tick && seg_last));

    // Sequence the frame segments, break and recovery mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
            idx <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (brk)         st <= ST_BRK;
                    else if (load)   st <= ST_START;
                end
                ST_START, ST_DATA, ST_PAR, ST_STOP: begin
                    if (tick) begin
                        if (!seg_last) begin
                            cnt <= cnt + 1'b1;
                        end else begin
                            cnt <= '0;
                            if (brk) begin
                                st <= ST_BRK;
                            end else begin
                                case (st)
                                    ST_START: begin
                                        st  <= ST_DATA;
                                        idx <= '0;
                                    end
                                    ST_DATA: begin
                                        idx <= idx + 1'b1;
                                        if (idx == l_len_m1) st <= l_par_en ? ST_PAR : ST_STOP;
                                    end
                                    ST_PAR:  st <= ST_STOP;
                                    default: st <= load ? ST_START : ST_IDLE;
                                endcase
                            end
                        end
                    end
                end
                ST_BRK: begin
                    cnt <= '0;
                    if (!brk) st <= ST_MARK;
                end
                ST_MARK: begin
                    if (tick) begin
                        if (seg_last) begin
                            cnt <= '0;
                            st  <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Capture the character and its settings on load; shift at each data bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            l_len_m1  <= '0;
            l_par_en  <= 1'b0;
            l_par_bit <= 1'b0;
            l_bit     <= CNT_W'(1);
            l_stop    <= CNT_W'(1);
        end else if (load) begin
            shreg     <= load_data;
            l_len_m1  <= len_m1;
            l_par_en  <= cfg_par_en;
            l_par_bit <= par_bit;
            l_bit     <= bit_ticks;
            l_stop    <= stop_ticks;
        end else if (st == ST_DATA && tick && seg_last && !brk) begin
            shreg <= shreg >> 1;
        end
    end

    // Drive the line level for the current segment.
    always_comb begin
        case (st)
            ST_START, ST_BRK: txd = 1'b0;
            ST_DATA:          txd = shreg[0];
            ST_PAR:           txd = l_par_bit;
            default:          txd = 1'b1;
        endcase
    end

    assign idle = (st == ST_IDLE);

    // R3: the start bit appears the cycle after a load
    assert_start_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !txd);

    // R9: releasing break always yields a high line next
    assert_mark_after_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BRK && !brk) |=> txd);
endmodule

// File: rtl/serial_tx_buffered.sv
// Top of the buffered asynchronous transmitter: holding register, timing decode and shift engine.
// Assumes: clk_en pulses at the sample rate; cts_n is already synchronous to clk.
module serial_tx_buffered #(
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 8,
    parameter int SLOW_TICKS = 1,
    parameter int MID_TICKS  = 16,
    parameter int FAST_TICKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        cfg_mult,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [1:0]        cfg_stop,
    input  logic              tx_enable,
    input  logic              send_break,
    input  logic              cts_n,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              eng_idle;
    logic              can_load;
    logic [CNT_W-1:0]  bit_ticks;
    logic [CNT_W-1:0]  stop_ticks;

    assign can_load = hold_full && tx_enable && !cts_n && !send_break;

    stx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    stx_timing #(
        .CNT_W      (CNT_W),
        .SLOW_TICKS (SLOW_TICKS),
        .MID_TICKS  (MID_TICKS),
        .FAST_TICKS (FAST_TICKS)
    ) u_timing (
        .mult       (cfg_mult),
        .stop       (cfg_stop),
        .bit_ticks  (bit_ticks),
        .stop_ticks (stop_ticks)
    );

    stx_engine #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (clk_en),
        .can_load    (can_load),
        .brk         (send_break),
        .load_data   (hold_data),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .bit_ticks   (bit_ticks),
        .stop_ticks  (stop_ticks),
        .load        (take),
        .txd         (txd),
        .idle        (eng_idle)
    );

    assign tx_ready = !hold_full;
    assign tx_empty = eng_idle && !hold_full;

    // R1: a transfer only happens while sending is permitted
    assert_xfer_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(tx_enable && !cts_n && !send_break));

    // R2: an accepted write drops ready on the next cycle
    assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tx_ready) |=> !tx_ready);

    // R7: an empty transmitter keeps the line marking
    assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);

    // R8: once low under break, the line stays low while break is held
    assert_break_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (send_break && !txd) |=> (!txd || !send_break));
endmodule

// File: tb/sim_serial_tx_buffered.sv
module sim_serial_tx_buffered;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] cfg_mult = 2'b01;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [1:0] cfg_stop = 2'b01;
    logic       tx_enable = 1'b0;
    logic       send_break = 1'b0;
    logic       cts_n = 1'b1;
    logic       txd, tx_ready, tx_empty;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit rand_tick = 0;
    string phase = "R11 reset";

    // reference model state
    int         mmode = 0;   // 0 idle, 1 frame, 2 break, 3 mark
    bit         mfull = 0;
    logic [7:0] mdata = 8'h00;
    bit         lv[$];
    int         du[$];
    int         mcnt = 0;

    always #2.5 clk = ~clk;

    serial_tx_buffered u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_stb(wr_stb), .wr_data(wr_data),
        .cfg_mult(cfg_mult), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop), .tx_enable(tx_enable),
        .send_break(send_break), .cts_n(cts_n), .txd(txd), .tx_ready(tx_ready),
        .tx_empty(tx_empty)
    );

    function automatic int bticks(logic [1:0] m);
        if (m == 2'b10) return 16;
        if (m == 2'b11) return 64;
        return 1;
    endfunction

    function automatic int sticks(logic [1:0] m, logic [1:0] s);
        int b = bticks(m);
        if (s == 2'b11) return 2 * b;
        if (s == 2'b10) return (b > 1) ? (b * 3) / 2 : b;
        return b;
    endfunction

    task automatic build();
        int b = bticks(cfg_mult);
        int n = 5 + int'(cfg_len);
        logic [7:0] msk = 8'hFF >> (8 - n);
        lv.delete(); du.delete();
        lv.push_back(1'b0); du.push_back(b);
        for (int i = 0; i < n; i++) begin
            lv.push_back(mdata[i]); du.push_back(b);
        end
        if (cfg_par_en) begin
            lv.push_back((^(mdata & msk)) ^ cfg_par_odd); du.push_back(b);
        end
        lv.push_back(1'b1); du.push_back(sticks(cfg_mult, cfg_stop));
        mcnt = 0;
        mmode = 1;
    endtask

    task automatic model_step();
        bit old_full = mfull;
        bit canload = mfull && tx_enable && !cts_n && !send_break;
        bit loaded = 0;
        if (!rst_n) begin
            mmode = 0; mfull = 0; mdata = 8'h00; mcnt = 0;
            lv.delete(); du.delete();
            return;
        end
        case (mmode)
            0: begin
                if (send_break) mmode = 2;
                else if (canload) begin build(); loaded = 1; end
            end
            1: if (clk_en) begin
                mcnt++;
                if (mcnt == du[0]) begin
                    mcnt = 0;
                    void'(lv.pop_front()); void'(du.pop_front());
                    if (send_break) begin
                        lv.delete(); du.delete(); mmode = 2;
                    end else if (lv.size() == 0) begin
                        if (canload) begin build(); loaded = 1; end
                        else mmode = 0;
                    end
                end
            end
            2: if (!send_break) begin mmode = 3; mcnt = 0; end
            default: if (clk_en) begin
                mcnt++;
                if (mcnt == bticks(cfg_mult)) begin mmode = 0; mcnt = 0; end
            end
        endcase
        if (loaded) mfull = 0;
        else if (wr_stb && !old_full) begin mfull = 1; mdata = wr_data; end
    endtask

    task automatic chk(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", phase, what, act, exp);
        end
    endtask

    task automatic compare();
        logic etxd = (mmode == 1) ? lv[0] : ((mmode == 2) ? 1'b0 : 1'b1);
        chk("txd", txd, etxd);
        chk("tx_ready", tx_ready, !mfull);
        chk("tx_empty", tx_empty, (mmode == 0) && !mfull);
    endtask

    // one clock: drive tick, predict, wait for the edge, compare away from it
    task automatic step();
        clk_en = rand_tick ? 1'($urandom % 2) : 1'b1;
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic send(logic [7:0] d);
        wr_stb = 1'b1; wr_data = d;
        step();
        wr_stb = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 8000; k++) begin
            if (mmode == 0 && !mfull) break;
            step();
        end
        repeat (3) step();
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 8000; k++) begin
            if (!mfull) break;
            step();
        end
    endtask

    initial begin
        @(negedge clk);
        repeat (4) step();
        rst_n = 1'b1;
        step();
        chk("R11 txd", txd, 1'b1);
        chk("R11 tx_ready", tx_ready, 1'b1);
        chk("R11 tx_empty", tx_empty, 1'b1);

        // R1: gating by enable and clear-to-send
        phase = "R1 gating";
        tx_enable = 1'b0; cts_n = 1'b0;
        send(8'hA5);
        repeat (20) step();
        chk("R1 line idle while disabled", txd, 1'b1);
        tx_enable = 1'b1; cts_n = 1'b1;
        repeat (20) step();
        chk("R1 line idle while cts high", txd, 1'b1);
        chk("R1 still holding", tx_ready, 1'b0);
        cts_n = 1'b0;
        drain();
        chk("R7 empty after frame", tx_empty, 1'b1);

        // R3 R4 R5: every length, parity and stop setting at one tick per bit
        phase = "R3 R4 R5 formats";
        for (int l = 0; l < 4; l++) begin
            for (int p = 0; p < 3; p++) begin
                for (int s = 1; s < 4; s++) begin
                    cfg_len = 2'(l); cfg_par_en = (p != 0); cfg_par_odd = (p == 2);
                    cfg_stop = 2'(s);
                    send(8'($urandom));
                    drain();
                end
            end
        end

        // R3 R5: slower multipliers with an irregular tick
        phase = "R3 R5 multipliers";
        rand_tick = 1;
        cfg_mult = 2'b10; cfg_stop = 2'b10; cfg_par_en = 1'b1; cfg_len = 2'b11;
        send(8'h6B); drain();
        cfg_mult = 2'b11; cfg_stop = 2'b11; cfg_len = 2'b01;
        send(8'h92); drain();
        cfg_stop = 2'b10; cfg_par_en = 1'b0;
        send(8'h3D); drain();
        rand_tick = 0;

        // R6: characters back to back
        phase = "R6 back-to-back";
        cfg_mult = 2'b10; cfg_stop = 2'b01; cfg_len = 2'b11;
        send(8'h81);
        wait_ready(); send(8'h7E);
        wait_ready(); send(8'h00);
        drain();

        // R2: writes while full are dropped, including the transfer cycle
        phase = "R2 overwrite";
        cfg_mult = 2'b01;
        tx_enable = 1'b0;
        send(8'h3C);
        send(8'hC3);
        step();
        chk("R2 ready low while holding", tx_ready, 1'b0);
        tx_enable = 1'b1;
        send(8'h99);
        drain();

        // R10: settings changed during the frame
        phase = "R10 mid-frame change";
        cfg_mult = 2'b10; cfg_len = 2'b10; cfg_par_en = 1'b1; cfg_stop = 2'b11;
        send(8'h5A);
        for (int k = 0; k < 300; k++) begin
            cfg_len = 2'($urandom); cfg_par_en = 1'($urandom); cfg_par_odd = 1'($urandom);
            cfg_stop = 2'($urandom);
            step();
        end
        cfg_stop = 2'b01;
        drain();

        // R8 R9: break during a frame and from idle
        phase = "R8 R9 break";
        cfg_len = 2'b11; cfg_par_en = 1'b0;
        send(8'hFF);
        repeat (40) step();
        send_break = 1'b1;
        repeat (100) step();
        chk("R8 line low under break", txd, 1'b0);
        send_break = 1'b0;
        step();
        chk("R9 line high after break", txd, 1'b1);
        drain();
        send_break = 1'b1;
        step();
        chk("R8 break from idle", txd, 1'b0);
        send(8'h11);
        repeat (10) step();
        chk("R8 no start under break", txd, 1'b0);
        send_break = 1'b0;
        repeat (8) step();
        chk("R9 mark before start", txd, 1'b1);
        drain();

        // R7: random traffic at one tick per bit
        phase = "R7 random stream";
        cfg_mult = 2'b01;
        for (int k = 0; k < 3000; k++) begin
            wr_stb = 1'($urandom % 3 == 0); wr_data = 8'($urandom);
            cts_n = 1'($urandom % 8 == 0);
            send_break = 1'($urandom % 50 == 0);
            cfg_len = 2'($urandom); cfg_par_en = 1'($urandom); cfg_stop = 2'($urandom);
            step();
        end
        wr_stb = 1'b0; cts_n = 1'b0; send_break = 1'b0;
        drain();
        chk("R7 empty at end", tx_empty, 1'b1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R3: got hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule